// File: doc/BRIEF.md
# Split-Edge Sensor Configuration SPI Master

This block drives the configuration port of an image sensor whose serial slave takes in data on the rising clock edge but presents its reply so that it has to be sampled on the falling edge. Every transaction opens with a 10-bit command word. The word holds a 9-bit register address followed by a direction flag. Chip select then stays low without a break while a data word of `DATA_W` bits (16 by default) is either shifted out to the sensor or shifted in from it. Both edges are therefore in use inside a single chip-select assertion, and bit counting does not depend on byte boundaries.

The host loads the address, flag, write data and clock divisor, then pulses `start` for one cycle. `busy` covers the whole transaction, including the quiet time after it. `done` pulses once when chip select is released, and from that cycle `rdData` holds the captured read word. One system-clock divider sets every serial half-period. With a system clock of about 100 MHz, divisors of roughly 50 to 500 cover the 100 kHz to 1 MHz range that configuration traffic needs.

Top module: `sensorCfgSpi`

## Requirements
- R1: The first 10 bits sampled on MOSI at SCLK rising edges are the 9-bit address, MSB first, followed by the flag bit (1 = write, 0 = read).
- R2: Each transaction has exactly 10 + DATA_W rising and 10 + DATA_W falling SCLK edges. On a write, the DATA_W write-data bits follow the command MSB first on MOSI.
- R3: On a read, MOSI is low for the whole data phase. MISO is captured on each data-phase falling edge, MSB first, and the result appears on `rdData`.
- R4: SCLK is low whenever chip select is high. MOSI never changes while SCLK stays high.
- R5: Every SCLK half-period lasts exactly N system clocks, where N is the `divHalf` value captured at `start` (a value below 2 acts as 2). Changing `divHalf` during a transaction has no effect on that transaction.
- R6: Chip select falls in the cycle after `start`. The first rising SCLK edge follows it by N clocks, chip select stays low throughout, and it rises N clocks after the last falling edge.
- R7: `busy` is high from the cycle after `start` until 2N clocks after chip select rises. `done` is high for exactly one cycle, in the cycle chip select rises.
- R8: `rdData` holds its value from `done` until a later read captures new bits. A write transaction leaves it unchanged.
- R9: A `start` pulse while `busy` is high is ignored. The current frame continues unchanged and no new chip-select assertion follows.
- R10: A synchronous reset, even in the middle of a transaction, returns the block to idle with chip select high, SCLK low, MOSI low, and `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transaction |
| regAddr | input | ADDR_W (9) | Sensor register address |
| writeFlag | input | 1 | 1 = write transaction, 0 = read transaction |
| wrData | input | DATA_W (16) | Data sent in a write |
| divHalf | input | DIV_W (16) | System clocks per SCLK half-period |
| miso | input | 1 | Serial data from the sensor |
| busy | output | 1 | Transaction in progress, including the release gap |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rdData | output | DATA_W (16) | Last word read from the sensor |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the sensor |

## Verification
The frame is exercised with addresses at both extremes, alternating patterns and single set bits. Each address is paired with both flag values, so a swapped flag position, a lost bit or a wrong bit order each produce a different failing word. Read replies use patterns different from the write data, which separates capture on the wrong edge or in the wrong order from plain echoing. The sweep repeats at divisors 2, 3 and 5 to expose off-by-one errors in the half-period, lead, trail and gap timing. Dedicated transactions change the divisor mid-frame, pulse start mid-frame, and reset mid-frame, to check latching, start rejection and abort.

// File: rtl/sensorCfgSpi_pkg.sv
package sensorCfgSpi_pkg;

  typedef struct packed {
    logic load;     // capture command and write data into the shifter
    logic shift;    // advance MOSI to the next bit (on a falling SCLK edge)
    logic capture;  // take one MISO bit into the read register
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } ctrlState_t;

endpackage

// File: rtl/spiCtrl.sv
module spiCtrl
  import sensorCfgSpi_pkg::*;
#(
  parameter int TOTAL_BITS = 26,
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             writeFlag,
  input  logic [DIV_W-1:0] divHalf,
  output dpStrobe_t        strobe,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W = $clog2(TOTAL_BITS + 1);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  ctrlState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic [CNT_W-1:0] bitsLeft;
  logic             gapHalf;
  logic             isWr;
  logic             tick;

  assign tick = (state != ST_IDLE) && (divCnt == divLim - DIV_W'(1));

  always_comb begin
    strobe.load    = (state == ST_IDLE) && start;
    strobe.shift   = (state == ST_SHIFT) && tick && sclk;
    strobe.capture = strobe.shift && !isWr && (bitsLeft <= CNT_W'(DATA_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      divCnt   <= '0;
      divLim   <= MIN_DIV;
      bitsLeft <= '0;
      gapHalf  <= 1'b0;
      isWr     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE) divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_LEAD;
          csN      <= 1'b0;
          busy     <= 1'b1;
          divCnt   <= '0;
          divLim   <= (divHalf < MIN_DIV) ? MIN_DIV : divHalf;
          bitsLeft <= CNT_W'(TOTAL_BITS);
          isWr     <= writeFlag;
        end
        ST_LEAD: if (tick) begin
          sclk  <= 1'b1;
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (sclk) begin
            sclk     <= 1'b0;
            bitsLeft <= bitsLeft - CNT_W'(1);
            if (bitsLeft == CNT_W'(1)) state <= ST_TRAIL;
          end else begin
            sclk <= 1'b1;
          end
        end
        ST_TRAIL: if (tick) begin
          csN     <= 1'b1;
          done    <= 1'b1;
          gapHalf <= 1'b0;
          state   <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gapHalf) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            gapHalf <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    csN |-> !sclk);

  assert_sclk_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(sclk));

  assert_done_with_cs_rise_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(csN));

  assert_busy_drop_cs_high_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> csN);

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state != ST_LEAD) || ($past(state) == ST_LEAD));

endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import sensorCfgSpi_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              writeFlag,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rdData
);

  localparam int TOTAL_BITS = ADDR_W + 1 + DATA_W;

  logic [TOTAL_BITS-1:0] txReg;
  logic [DATA_W-1:0]     rxReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      txReg <= '0;
      rxReg <= '0;
    end else begin
      if (strobe.load)
        txReg <= {regAddr, writeFlag, writeFlag ? wrData : {DATA_W{1'b0}}};
      else if (strobe.shift)
        txReg <= {txReg[TOTAL_BITS-2:0], 1'b0};
      if (strobe.capture)
        rxReg <= {rxReg[DATA_W-2:0], miso};
    end
  end

  assign mosi   = txReg[TOTAL_BITS-1];
  assign rdData = rxReg;

  assert_read_mosi_low_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |-> !mosi);

endmodule

// File: rtl/sensorCfgSpi.sv
module sensorCfgSpi
  import sensorCfgSpi_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              writeFlag,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              csN,
  output logic              sclk,
  output logic              mosi
);

  localparam int TOTAL_BITS = ADDR_W + 1 + DATA_W;

  dpStrobe_t strobe;

  spiCtrl #(.TOTAL_BITS(TOTAL_BITS), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .writeFlag(writeFlag),
    .divHalf(divHalf), .strobe(strobe), .csN(csN), .sclk(sclk),
    .busy(busy), .done(done)
  );

  spiDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .regAddr(regAddr),
    .writeFlag(writeFlag), .wrData(wrData), .miso(miso),
    .mosi(mosi), .rdData(rdData)
  );

  assert_mosi_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
    sclk |=> ($stable(mosi) || !sclk));

  assert_cs_low_while_clocking_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !csN && busy);

endmodule

// File: tb/sensorCfgSpi_bench.sv
module sensorCfgSpi_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [8:0]  regAddr = '0;
  logic        writeFlag = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] divHalf = 16'd2;
  logic        miso = 1'b0;
  logic        busy, done, csN, sclk, mosi;
  logic [15:0] rdData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sensorCfgSpi u_sensorCfgSpi (
    .clk(clk), .rst(rst), .start(start), .regAddr(regAddr),
    .writeFlag(writeFlag), .wrData(wrData), .divHalf(divHalf), .miso(miso),
    .busy(busy), .done(done), .rdData(rdData), .csN(csN), .sclk(sclk),
    .mosi(mosi)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic runTxn(input int n, input logic [8:0] a, input bit wr,
                        input logic [15:0] wd, input logic [15:0] pat,
                        input bit poke, input bit chgDiv);
    logic [9:0]  cmdGot = '0;
    logic [15:0] dataGot = '0;
    logic [15:0] expData;
    bit prevSclk, prevCs, prevMosi, leadOk = 0, trailOk = 0, doneAtRise = 0;
    bit poked = 0, pokeOn = 0;
    int since = 0, cyc = 0, riseCnt = 0, fallCnt = 0, csRiseCyc = -1;
    int halfErr = 0, mosiErr = 0, idleErr = 0, doneCnt = 0, csFalls = 0;
    @(negedge clk);
    divHalf = 16'(n); regAddr = a; writeFlag = wr; wrData = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!csN && busy, "R6", "cs low and busy after start", {csN, busy}, 2'b01);
    prevSclk = sclk; prevCs = csN; prevMosi = mosi;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++; since++;
      if (done) doneCnt++;
      if (sclk && !prevSclk) begin
        if (riseCnt == 0) leadOk = (since == n);
        else if (since != n) halfErr++;
        if (riseCnt < 10) cmdGot = {cmdGot[8:0], mosi};
        else dataGot = {dataGot[14:0], mosi};
        if (riseCnt >= 10 && riseCnt < 26) miso = pat[25 - riseCnt];
        riseCnt++; since = 0;
      end else if (!sclk && prevSclk) begin
        if (since != n) halfErr++;
        fallCnt++; since = 0;
      end
      if (mosi != prevMosi && sclk && prevSclk) mosiErr++;
      if (csN && sclk) idleErr++;
      if (csN && !prevCs) begin
        trailOk = (since == n); doneAtRise = done; csRiseCyc = cyc; since = 0;
      end
      if (!csN && prevCs) csFalls++;
      prevSclk = sclk; prevCs = csN; prevMosi = mosi;
      // stimulus after sampling
      if (pokeOn) begin start = 1'b0; pokeOn = 0; end
      else if (poke && riseCnt == 4 && !poked) begin
        start = 1'b1; regAddr = ~a; writeFlag = ~wr; poked = 1; pokeOn = 1;
      end
      if (chgDiv && riseCnt == 2) divHalf = 16'(n + 3);
    end
    miso = 1'b0; regAddr = a; writeFlag = wr; divHalf = 16'(n);
    expData = wr ? wd : 16'h0000;
    check(cmdGot == {a, wr}, "R1", "command word", cmdGot, {a, wr});
    check(riseCnt == 26 && fallCnt == 26, "R2", "edge counts", riseCnt * 100 + fallCnt, 2626);
    check(dataGot == expData, wr ? "R2" : "R3", "mosi data phase", dataGot, expData);
    if (!wr) check(rdData == pat, "R3", "read capture", rdData, pat);
    check(mosiErr == 0 && idleErr == 0, "R4", "mosi/sclk idle errors", mosiErr + idleErr, 0);
    check(halfErr == 0, chgDiv ? "R5 latched" : "R5", "half-period errors", halfErr, 0);
    check(leadOk && trailOk, "R6", "lead/trail spacing", {leadOk, trailOk}, 2'b11);
    check(doneCnt == 1 && doneAtRise, "R7", "done pulse", doneCnt, 1);
    check(cyc - csRiseCyc == 2 * n, "R7", "busy gap after cs rise", cyc - csRiseCyc, 2 * n);
    if (poke) check(csFalls == 0 && poked, "R9", "extra cs assertions", csFalls, 0);
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check(csN && !sclk && !busy && !done && !mosi, "R10", "reset outputs",
          {csN, sclk, busy, done, mosi}, 5'b10000);
    rst = 1'b0;
    foreach (divs[i]) ;
    for (int ni = 0; ni < 3; ni++) begin
      int n = (ni == 0) ? 2 : (ni == 1) ? 3 : 5;
      for (int ai = 0; ai < 5; ai++) begin
        logic [8:0] a = (ai == 0) ? 9'h000 : (ai == 1) ? 9'h1FF : (ai == 2) ? 9'h155 :
                        (ai == 3) ? 9'h0AA : 9'h101;
        logic [15:0] wd  = 16'((ai * 4099 + n * 977) ^ 16'hA5C3);
        logic [15:0] pat = 16'((ai * 7919 + n * 311) ^ 16'h3C96);
        runTxn(n, a, 1'b1, wd, pat, 0, 0);
        runTxn(n, a, 1'b0, wd, pat, 0, 0);
      end
    end
    // R8: read result holds while idle and across a write
    held = rdData;
    repeat (7) @(negedge clk);
    check(rdData == held, "R8", "rdData idle hold", rdData, held);
    runTxn(2, 9'h0F0, 1'b1, 16'hFFFF, 16'h1234, 0, 0);
    check(rdData == held, "R8", "rdData after write", rdData, held);
    // R5 divisor latched, R9 start while busy
    runTxn(3, 9'h12C, 1'b0, 16'h0, 16'hBEEF, 0, 1);
    runTxn(2, 9'h033, 1'b1, 16'h8001, 16'h0, 1, 0);
    runTxn(2, 9'h1C4, 1'b0, 16'h0, 16'h7E81, 1, 0);
    // R10 reset mid-transaction
    @(negedge clk);
    divHalf = 16'd3; regAddr = 9'h1AB; writeFlag = 1'b1; wrData = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(csN && !sclk && !busy && !done && !mosi, "R10", "mid-frame reset",
          {csN, sclk, busy, done, mosi}, 5'b10000);
    rst = 1'b0;
    runTxn(2, 9'h0C3, 1'b0, 16'h0, 16'h5AA5, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int divs[1] = '{0};

endmodule